// File: doc/BRIEF.md
# Clock Source Selection Register Bank

This block holds the control registers that pick, divide and gate the clock for a set of integer divider channels and a larger set of base (consumer-facing) clock channels. Each channel register carries a 5-bit source code, an active-high disable bit and, on divider channels only, a divide field. The block does not switch any clock itself. It publishes the stored settings on per-channel output ports, where clock muxes, dividers and gating cells elsewhere pick them up.

A write to a channel checks the requested source code against that channel's own list of allowed parents. A code that is not on the list leaves the stored source unchanged and sets a sticky error flag. The block also works out an effective-enable status for every channel. A channel counts as running only when its own gate is open and its selected parent is running. The status of the external and oscillator sources comes from an input vector. The status of a divider used as a parent is that divider's own effective enable, so the status follows the whole chain.

Source codes (these values are decoded downstream): 0 32 kHz oscillator, 1 internal RC oscillator, 2 Ethernet receive clock, 3 Ethernet transmit clock, 4 general-purpose clock input, 6 crystal oscillator, 7 USB PLL, 8 audio PLL, 9 main PLL, 12 to 16 dividers A to E. Codes 5, 10, 11 and 17 to 31 name no source.

Top module: `cksel_bank`

## Requirements
- R1: After reset, every writable channel reads source code 1 with gate open and divide field zero, and `sel_err` is low.
- R2: A channel register is laid out as follows: bits 28:24 hold the source code, bit 0 is the disable bit (1 = gated off), and on divider channels the divide field starts at bit 2 and is 2 bits wide for divider A, 4 bits for B, C and D, and 8 bits for E. All other bits read 0, and `bus_rdata` shows the register at `bus_addr` in the same cycle.
- R3: Word addresses 0 to 4 select dividers A to E, and address 8+n selects base channel n. Addresses 5 to 7 and those above the last base channel read 0 and ignore writes.
- R4: Divider A accepts codes 0 to 4 and 6 to 9. Dividers B to E accept codes 0 to 4, 6, 8, 9 and 12 (divider A), and reject 7.
- R5: Base channel 0 (safe) always reads code 1 with the disable bit 0, ignores every write, and is enabled exactly when source 1 is running.
- R6: Base channel 1 accepts only code 7. Base channels 3, 20, 26 and 27 accept codes 0 to 4, 6 to 9 and 12 to 16. The other non-reserved base channels accept the same set without 7.
- R7: A write with a code that is not allowed keeps the stored code but still updates the gate and divide fields, and sets `sel_err`, which stays high until reset.
- R8: A channel's enable output is high only if its disable bit is 0 and its selected parent is running. For codes 0 to 4 and 6 to 9 the parent's status is `src_on` at that code, for codes 12 to 16 it is the effective enable of the selected divider, and any other code is never running.
- R9: Base channels 21 to 24 are reserved: they read 0, drive source code 0 and enable 0, and ignore writes without raising `sel_err`.
- R10: The `div_sel`, `div_val` and `base_sel` outputs equal the stored register fields of each channel, with `div_val` zero-extended to 8 bits per divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| src_on | input | 12 | Running status of source codes 0 to 11 |
| div_sel | output | 25 | Source code per divider, 5 bits each, A in the low bits |
| div_val | output | 40 | Divide value per divider, 8 bits each |
| div_on | output | 5 | Effective enable per divider |
| base_sel | output | 140 | Source code per base channel, 5 bits each |
| base_on | output | 28 | Effective enable per base channel |
| sel_err | output | 1 | Sticky flag for a rejected source code |

## Verification
The checker checks on every cycle the invariants that hold at all times: the error flag stays set once raised, the safe and reserved channels keep fixed outputs, the USB0 base channel never holds a code other than 1 or 7, divider A never holds a divider code, and a divider that selects divider A can only be enabled while A is enabled. It also checks two one-cycle write responses: a rejected code leaves the selector stable, and setting the disable bit turns the channel off. Only the bench's scenarios can show that each channel's full allowed list is right, that the divide fields are truncated to the correct widths, that unmapped addresses have no effect, and that the enable outputs follow the source chain under mixed `src_on` patterns.

// File: rtl/cksel_pkg.sv
package cksel_pkg;
    localparam int SEL_W    = 5;
    localparam int SEL_LSB  = 24;
    localparam int DIV_LSB  = 2;
    localparam int N_DIV    = 5;

    localparam logic [SEL_W-1:0] SRC_RCOSC   = 5'd1;
    localparam logic [SEL_W-1:0] SRC_PLL_USB = 5'd7;

    // bit k set = source code k names a real source outside the divider set
    localparam logic [31:0] LEAF_MASK   = 32'h0000_03DF;
    localparam logic [31:0] DIVA_MASK   = 32'h0000_03DF;
    localparam logic [31:0] DIVBE_MASK  = 32'h0000_135F;
    localparam logic [31:0] ALL_MASK    = 32'h0001_F3DF;
    localparam logic [31:0] COMMON_MASK = 32'h0001_F35F;
    localparam logic [31:0] SAFE_MASK   = 32'h0000_0002;
    localparam logic [31:0] USB0_MASK   = 32'h0000_0080;

    function automatic logic [31:0] div_allow(input int i);
        return (i == 0) ? DIVA_MASK : DIVBE_MASK;
    endfunction

    function automatic logic [31:0] base_allow(input int n);
        if (n == 0)                       return SAFE_MASK;
        if (n == 1)                       return USB0_MASK;
        if (n >= 21 && n <= 24)           return 32'h0;
        if (n == 3 || n == 20 || n >= 26) return ALL_MASK;
        return COMMON_MASK;
    endfunction
endpackage

// File: rtl/cksel_div_chan.sv
module cksel_div_chan
    import cksel_pkg::*;
#(
    parameter int          DIV_W = 4,
    parameter logic [31:0] ALLOW = DIVBE_MASK
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] w_sel,
    input  logic             w_gate,
    input  logic [DIV_W-1:0] w_div,
    input  logic [31:0]      par_ok,
    output logic [SEL_W-1:0] sel_q,
    output logic [DIV_W-1:0] div_q,
    output logic             on,
    output logic [31:0]      rd,
    output logic             bad
);
    logic gate_q;

    assign bad = wr_en && !ALLOW[w_sel];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q  <= SRC_RCOSC;
            gate_q <= 1'b0;
            div_q  <= '0;
        end else if (wr_en) begin
            gate_q <= w_gate;
            div_q  <= w_div;
            if (ALLOW[w_sel]) sel_q <= w_sel;
        end
    end

    assign on = !gate_q && par_ok[sel_q];

    always_comb begin
        rd = '0;
        rd[SEL_LSB +: SEL_W] = sel_q;
        rd[DIV_LSB +: DIV_W] = div_q;
        rd[0]                = gate_q;
    end
endmodule

// File: rtl/cksel_base_chan.sv
module cksel_base_chan
    import cksel_pkg::*;
#(
    parameter logic [31:0] ALLOW = COMMON_MASK
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] w_sel,
    input  logic             w_gate,
    input  logic [31:0]      par_ok,
    output logic [SEL_W-1:0] sel_q,
    output logic             on,
    output logic [31:0]      rd,
    output logic             bad
);
    logic gate_q;

    assign bad = wr_en && !ALLOW[w_sel];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q  <= SRC_RCOSC;
            gate_q <= 1'b0;
        end else if (wr_en) begin
            gate_q <= w_gate;
            if (ALLOW[w_sel]) sel_q <= w_sel;
        end
    end

    assign on = !gate_q && par_ok[sel_q];

    always_comb begin
        rd = '0;
        rd[SEL_LSB +: SEL_W] = sel_q;
        rd[0]                = gate_q;
    end
endmodule

// File: rtl/cksel_bank.sv
module cksel_bank
    import cksel_pkg::*;
#(
    parameter int N_BASE   = 28,
    parameter int ADDR_W   = 6,
    parameter int BASE_OFS = 8,
    parameter int N_SRC_IN = 12,
    parameter int DIVW_A   = 2,
    parameter int DIVW_BD  = 4,
    parameter int DIVW_E   = 8,
    parameter int SAFE_IDX = 0,
    parameter int RSV_LO   = 21,
    parameter int RSV_HI   = 24
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_we,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [31:0]               bus_wdata,
    output logic [31:0]               bus_rdata,
    input  logic [N_SRC_IN-1:0]       src_on,
    output logic [SEL_W*N_DIV-1:0]    div_sel,
    output logic [DIVW_E*N_DIV-1:0]   div_val,
    output logic [N_DIV-1:0]          div_on,
    output logic [SEL_W*N_BASE-1:0]   base_sel,
    output logic [N_BASE-1:0]         base_on,
    output logic                      sel_err
);
    localparam int DIVW_MAX = DIVW_E;

    logic [31:0]      leaf_ok, par_be, par_base;
    logic             on_a;
    logic [N_DIV-2:0] on_hi;
    logic [N_DIV-1:0] div_bad;
    logic [N_BASE-1:0] base_bad;
    logic [31:0]      div_rd  [N_DIV];
    logic [31:0]      base_rd [N_BASE];
    logic             err_q;
    logic             unused_wbits;

    assign unused_wbits = ^{bus_wdata[31:29], bus_wdata[23:10], bus_wdata[1]};

    // parent status: leaves, then divider A, then all dividers
    assign leaf_ok  = 32'(src_on) & LEAF_MASK;
    assign par_be   = leaf_ok | (32'(on_a) << 12);
    assign par_base = leaf_ok | (32'(div_on) << 12);
    assign div_on   = {on_hi, on_a};

    // divider A: its parents are leaves only
    logic [DIVW_A-1:0] div_a_q;
    cksel_div_chan #(.DIV_W(DIVW_A), .ALLOW(div_allow(0))) u_div_a (
        .clk(clk), .rst_n(rst_n),
        .wr_en(bus_we && bus_addr == ADDR_W'(0)),
        .w_sel(bus_wdata[SEL_LSB +: SEL_W]), .w_gate(bus_wdata[0]),
        .w_div(bus_wdata[DIV_LSB +: DIVW_A]), .par_ok(leaf_ok),
        .sel_q(div_sel[SEL_W-1:0]), .div_q(div_a_q), .on(on_a),
        .rd(div_rd[0]), .bad(div_bad[0])
    );
    assign div_val[DIVW_MAX-1:0] = DIVW_MAX'(div_a_q);

    for (genvar i = 1; i < N_DIV; i++) begin : g_div
        localparam int W = (i == N_DIV-1) ? DIVW_E : DIVW_BD;
        logic [W-1:0] dq;
        cksel_div_chan #(.DIV_W(W), .ALLOW(div_allow(i))) u_div (
            .clk(clk), .rst_n(rst_n),
            .wr_en(bus_we && bus_addr == ADDR_W'(i)),
            .w_sel(bus_wdata[SEL_LSB +: SEL_W]), .w_gate(bus_wdata[0]),
            .w_div(bus_wdata[DIV_LSB +: W]), .par_ok(par_be),
            .sel_q(div_sel[SEL_W*i +: SEL_W]), .div_q(dq), .on(on_hi[i-1]),
            .rd(div_rd[i]), .bad(div_bad[i])
        );
        assign div_val[DIVW_MAX*i +: DIVW_MAX] = DIVW_MAX'(dq);
    end

    for (genvar n = 0; n < N_BASE; n++) begin : g_base
        if (n == SAFE_IDX) begin : g_safe
            assign base_sel[SEL_W*n +: SEL_W] = SRC_RCOSC;
            assign base_on[n]  = par_base[SRC_RCOSC];
            assign base_rd[n]  = 32'(SRC_RCOSC) << SEL_LSB;
            assign base_bad[n] = 1'b0;
        end else if (n >= RSV_LO && n <= RSV_HI) begin : g_rsv
            assign base_sel[SEL_W*n +: SEL_W] = '0;
            assign base_on[n]  = 1'b0;
            assign base_rd[n]  = '0;
            assign base_bad[n] = 1'b0;
        end else begin : g_live
            cksel_base_chan #(.ALLOW(base_allow(n))) u_base (
                .clk(clk), .rst_n(rst_n),
                .wr_en(bus_we && bus_addr == ADDR_W'(BASE_OFS + n)),
                .w_sel(bus_wdata[SEL_LSB +: SEL_W]), .w_gate(bus_wdata[0]),
                .par_ok(par_base),
                .sel_q(base_sel[SEL_W*n +: SEL_W]), .on(base_on[n]),
                .rd(base_rd[n]), .bad(base_bad[n])
            );
        end
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < N_DIV; i++)
            if (bus_addr == ADDR_W'(i)) bus_rdata = div_rd[i];
        for (int n = 0; n < N_BASE; n++)
            if (bus_addr == ADDR_W'(BASE_OFS + n)) bus_rdata = base_rd[n];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 err_q <= 1'b0;
        else if (|{div_bad, base_bad}) err_q <= 1'b1;
    end
    assign sel_err = err_q;
endmodule

// File: rtl/cksel_bank_chk.sv
module cksel_bank_chk
    import cksel_pkg::*;
#(
    parameter int N_BASE   = 28,
    parameter int ADDR_W   = 6,
    parameter int N_SRC_IN = 12,
    parameter int RSV_LO   = 21,
    parameter int RSV_HI   = 24
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    bus_we,
    input logic [ADDR_W-1:0]       bus_addr,
    input logic [31:0]             bus_wdata,
    input logic [N_SRC_IN-1:0]     src_on,
    input logic [SEL_W*N_DIV-1:0]  div_sel,
    input logic [N_DIV-1:0]        div_on,
    input logic [SEL_W*N_BASE-1:0] base_sel,
    input logic [N_BASE-1:0]       base_on,
    input logic                    sel_err
);
    p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sel_err |=> sel_err);

    p_reject_keeps_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(1) && bus_wdata[SEL_LSB +: SEL_W] == SRC_PLL_USB)
        |=> $stable(div_sel[SEL_W +: SEL_W]));

    p_safe_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        base_sel[SEL_W-1:0] == SRC_RCOSC && base_on[0] == src_on[1]);

    p_usb0_codes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        base_sel[SEL_W +: SEL_W] == SRC_RCOSC || base_sel[SEL_W +: SEL_W] == SRC_PLL_USB);

    p_reserved_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        base_on[RSV_HI:RSV_LO] == '0 &&
        base_sel[SEL_W*RSV_LO +: SEL_W*(RSV_HI-RSV_LO+1)] == '0);

    p_div_a_no_div_r4: assert property (@(posedge clk) disable iff (!rst_n)
        div_sel[SEL_W-1:0] < 5'd12);

    p_chain_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (div_on[1] && div_sel[SEL_W +: SEL_W] == 5'd12) |-> div_on[0]);

    p_gate_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(0) && bus_wdata[0]) |=> !div_on[0]);
endmodule

bind cksel_bank cksel_bank_chk #(
    .N_BASE(N_BASE), .ADDR_W(ADDR_W), .N_SRC_IN(N_SRC_IN),
    .RSV_LO(RSV_LO), .RSV_HI(RSV_HI)
) chk_i (.*);

// File: tb/cksel_bank_tb_top.sv
module cksel_bank_tb_top;
    localparam int NB = 28;
    localparam int NC = 5 + NB;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         bus_we;
    logic [5:0]   bus_addr;
    logic [31:0]  bus_wdata;
    logic [31:0]  bus_rdata;
    logic [11:0]  src_on;
    logic [24:0]  div_sel;
    logic [39:0]  div_val;
    logic [4:0]   div_on;
    logic [139:0] base_sel;
    logic [27:0]  base_on;
    logic         sel_err;

    always #4 clk = ~clk;

    cksel_bank dut_i (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_on(src_on),
        .div_sel(div_sel), .div_val(div_val), .div_on(div_on),
        .base_sel(base_sel), .base_on(base_on), .sel_err(sel_err)
    );

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 1'b0;
    string tag    = "";

    logic [4:0] m_sel  [NC];
    logic       m_gate [NC];
    logic [7:0] m_div  [NC];
    logic       m_err;
    logic       e_on   [NC];

    // 0 divider, 1 safe, 2 reserved, 3 ordinary base
    function automatic int kind(input int c);
        if (c < 5) return 0;
        if (c == 5) return 1;
        if (c - 5 >= 21 && c - 5 <= 24) return 2;
        return 3;
    endfunction

    function automatic bit leaf_ok(input int code);
        return code inside {0, 1, 2, 3, 4, 6, 7, 8, 9};
    endfunction

    function automatic bit allowed(input int c, input int code);
        int n;
        if (c == 0) return leaf_ok(code);
        if (c < 5)  return (leaf_ok(code) && code != 7) || code == 12;
        n = c - 5;
        if (n == 1) return code == 7;
        if (n == 3 || n == 20 || n == 26 || n == 27)
            return leaf_ok(code) || (code >= 12 && code <= 16);
        return (leaf_ok(code) && code != 7) || (code >= 12 && code <= 16);
    endfunction

    function automatic int dw(input int c);
        if (c == 0) return 2;
        if (c == 4) return 8;
        return 4;
    endfunction

    function automatic int addr_of(input int c);
        return (c < 5) ? c : 8 + c - 5;
    endfunction

    function automatic logic [31:0] mk(input int sel, input int dv, input bit g);
        return (32'(sel) << 24) | (32'(dv & 255) << 2) | 32'(g);
    endfunction

    function automatic bit par_val(input int code);
        if (leaf_ok(code)) return src_on[code];
        if (code >= 12 && code <= 16) return e_on[code - 12];
        return 1'b0;
    endfunction

    task automatic model_reset();
        for (int c = 0; c < NC; c++) begin
            m_sel[c]  = (kind(c) == 2) ? 5'd0 : 5'd1;
            m_gate[c] = 1'b0;
            m_div[c]  = 8'd0;
        end
        m_err = 1'b0;
    endtask

    task automatic model_write(input int c, input logic [31:0] d);
        if (kind(c) == 1 || kind(c) == 2) return;
        m_gate[c] = d[0];
        m_div[c]  = (c < 5) ? 8'((d >> 2) & ((32'd1 << dw(c)) - 1)) : 8'd0;
        if (allowed(c, int'(d[28:24]))) m_sel[c] = d[28:24];
        else m_err = 1'b1;
    endtask

    task automatic compute_on();
        e_on[0] = !m_gate[0] && par_val(int'(m_sel[0]));
        for (int c = 1; c < 5; c++) e_on[c] = !m_gate[c] && par_val(int'(m_sel[c]));
        for (int c = 5; c < NC; c++) begin
            if (kind(c) == 1)      e_on[c] = src_on[1];
            else if (kind(c) == 2) e_on[c] = 1'b0;
            else                   e_on[c] = !m_gate[c] && par_val(int'(m_sel[c]));
        end
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL [%s] %s: actual %h expected %h", tag, req, act, exp);
        end
    endtask

    task automatic check_all();
        logic [31:0] er;
        logic [4:0]  as;
        int          k;
        compute_on();
        for (int c = 0; c < NC; c++) begin
            k = kind(c);
            bus_addr = 6'(addr_of(c));
            #1;
            er = '0;
            if (k == 1) er = mk(1, 0, 1'b0);
            else if (k != 2) begin
                er[28:24] = m_sel[c];
                er[9:2]   = m_div[c];
                er[0]     = m_gate[c];
            end
            chk($sformatf("%s readback ch%0d", (k == 1) ? "R5" : (k == 2) ? "R9" : "R2", c),
                bus_rdata, er);
            as = (c < 5) ? div_sel[5*c +: 5] : base_sel[5*(c-5) +: 5];
            chk($sformatf("R10 sel ch%0d", c), 32'(as), 32'((k == 1) ? 5'd1 : m_sel[c]));
            chk($sformatf("R8 enable ch%0d", c),
                32'((c < 5) ? div_on[c] : base_on[c-5]), 32'(e_on[c]));
            if (c < 5) chk($sformatf("R10 divide ch%0d", c), 32'(div_val[8*c +: 8]), 32'(m_div[c]));
        end
        chk("R7 error flag", 32'(sel_err), 32'(m_err));
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_we    = 1'b1;
        bus_addr  = 6'(a);
        bus_wdata = d;
        @(posedge clk);
        #1;
        bus_we = 1'b0;
        if (a < 5) model_write(a, d);
        else if (a >= 8 && a < 8 + NB) model_write(a - 3, d);
    endtask

    initial begin
        int a, c, sel;
        logic [31:0] d;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; src_on = '0;
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);

        tag = "R1"; check_all();
        src_on = '1; tag = "R1 sources on"; check_all();

        tag = "R4";
        wr(0, mk(7, 3, 1'b0));
        wr(1, mk(12, 9, 1'b0));
        wr(2, mk(8, 5, 1'b0));
        check_all();
        src_on[7] = 1'b0; check_all();

        tag = "R7";
        wr(1, mk(7, 2, 1'b1));
        wr(3, mk(11, 1, 1'b0));
        check_all();

        tag = "R5";
        wr(8, mk(9, 0, 1'b1));
        src_on[1] = 1'b0; check_all();
        src_on[1] = 1'b1;

        tag = "R9";
        wr(8 + 22, mk(1, 5, 1'b0));
        check_all();

        tag = "R6";
        wr(9, mk(9, 0, 1'b0));
        wr(9, mk(7, 0, 1'b0));
        wr(8 + 3, mk(7, 0, 1'b0));
        wr(8 + 4, mk(7, 0, 1'b0));
        wr(8 + 27, mk(16, 0, 1'b0));
        check_all();

        tag = "R3";
        wr(6, mk(2, 7, 1'b1));
        wr(63, mk(2, 7, 1'b1));
        check_all();

        tag = "R2";
        wr(4, mk(12, 255, 1'b0) | 32'hE0FF_FC02);
        wr(0, mk(1, 255, 1'b0) | 32'hE0FF_FC02);
        check_all();

        tag = "R8";
        src_on = 12'hC20;
        wr(8 + 5, mk(12, 0, 1'b0));
        wr(8 + 6, mk(14, 0, 1'b0));
        check_all();
        src_on = 12'hFDF; check_all();

        tag = "RND";
        for (int it = 0; it < 400; it++) begin
            if ($urandom_range(0, 9) == 0) begin
                a = ($urandom_range(0, 1) == 0) ? int'($urandom_range(5, 7))
                                                : int'($urandom_range(8 + NB, 63));
            end else begin
                c = int'($urandom_range(0, NC - 1));
                a = addr_of(c);
            end
            sel = ($urandom_range(0, 1) == 0) ? int'($urandom_range(0, 16))
                                              : int'($urandom_range(0, 31));
            d = mk(sel, int'($urandom_range(0, 255)), $urandom_range(0, 3) == 0)
                | ($urandom & 32'hE0FF_FC02);
            wr(a, d);
            if (it % 25 == 0) src_on = 12'($urandom);
            if (it % 8 == 7) check_all();
        end
        check_all();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL [watchdog] run did not finish: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule